// File: doc/BRIEF.md
# Link Power State Request Controller

This block sits between a software-writable 4-bit interface control field and the link layer of a serial storage port. Software writes a command code into the field. The block validates the command against the link state and the port's activity, then issues a one-cycle request strobe to the link layer, or it drops the command. The field returns to zero one cycle after it takes a value, which tells software that another command can be accepted. The earlier transition may still be in progress at that point.

The block keeps the current link power state. It raises Partial or Slumber requests only from Active, and it waits for the device to grant or deny them. It also owns the device-sleep pin. That pin asserts only after PHY-ready has been seen since the pin last dropped. Once asserted, the pin is held for a loadable minimum time before an Active request can release it. All pins are plain level or pulse signals: there is no data stream and no back-pressure. A write that arrives while the link is busy, or while the field is non-zero, is simply lost.

Top module: `link_pwr_req_ctrl`

## Requirements
- R1: After reset, the field reads 0, the link state is Active (code 0), the device-sleep pin is low and no request strobe is high.
- R2: A write is taken only when `link_idle` is 1 and the field reads 0. A taken value is visible on `ctl_field` for exactly one cycle, then the field reads 0. Any other write leaves the field at 0.
- R3: The command codes are 1 Active, 2 Partial, 6 Slumber and 8 Device-Sleep. Partial or Slumber taken in Active gives a one-cycle strobe on `req_partial` or `req_slumber` in the cycle after the field showed the code. A later `lp_grant` moves `link_state` to Partial (1) or Slumber (2). A later `lp_deny` leaves the state unchanged. At most one strobe is high at a time.
- R4: A request for the state the link is already in produces no strobe and no state change.
- R5: Partial or Slumber requested while in a different low-power state (Partial, Slumber or Device-Sleep, code 3) is dropped.
- R6: Active requested from Partial or Slumber gives a one-cycle `req_active` strobe, and the state becomes Active in the same cycle.
- R7: Device-Sleep is entered only if every bit of `cmd_issue` and `tag_active` is 0. Otherwise the request is dropped.
- R8: When `dslp_slumber_only` is 1, Device-Sleep is entered only if `pwr_status` equals 6. When it is 0, Device-Sleep may be entered from any other state, including Partial and Slumber.
- R9: `dslp_pin` is high only in Device-Sleep. It rises only after `phy_ready` has been seen high since the previous fall of the pin (or since reset).
- R10: When the pin rises, the hold timer loads `dslp_hold`. Active requested in Device-Sleep drops the pin, pulses `req_active` and returns to Active only once the timer reads 0. The pin therefore stays high for at least `dslp_hold`+1 cycles.
- R11: Codes 0, 3 to 5, 7 and 9 to 15 cause no strobe and no state change. They still read back for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Software write strobe for the control field |
| ctl_wr_data | input | 4 | Command code written |
| link_idle | input | 1 | Link layer is in its idle state |
| cmd_issue | input | NSLOT | Command-issue vector |
| tag_active | input | NSLOT | Active-tag vector |
| phy_ready | input | 1 | Physical layer ready |
| dslp_slumber_only | input | 1 | Capability: Device-Sleep only from Slumber |
| pwr_status | input | 4 | Current interface power status (6 = Slumber) |
| lp_grant | input | 1 | Device accepted the pending Partial/Slumber request |
| lp_deny | input | 1 | Device rejected the pending Partial/Slumber request |
| dslp_hold | input | TMR_W | Minimum device-sleep assertion count |
| ctl_field | output | 4 | Readable control field |
| link_state | output | 2 | 0 Active, 1 Partial, 2 Slumber, 3 Device-Sleep |
| req_active | output | 1 | One-cycle Active request strobe |
| req_partial | output | 1 | One-cycle Partial request strobe |
| req_slumber | output | 1 | One-cycle Slumber request strobe |
| dslp_pin | output | 1 | Device-sleep pin |

## Verification
A write shows on `ctl_field` one edge after it is driven. The strobe and any Active or Device-Sleep state change follow one edge later. A grant or deny takes effect one edge after it is sampled. The pin rises two edges after `phy_ready` is first sampled high in Device-Sleep, and it falls `dslp_hold`+1 edges after it rises. A behavioural model in the bench advances on every rising edge from the same inputs. All outputs are compared with it at each falling edge. The directed checks sample at the falling edge that follows exactly the number of edges listed above.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    LS_ACTIVE  = 2'd0,
    LS_PARTIAL = 2'd1,
    LS_SLUMBER = 2'd2,
    LS_DEVSLP  = 2'd3
  } lstate_t;

  typedef enum logic [2:0] {
    RQ_NONE,
    RQ_ACTIVE,
    RQ_PARTIAL,
    RQ_SLUMBER,
    RQ_DEVSLP
  } rq_t;

  localparam logic [CODE_W-1:0] CODE_ACTIVE  = 4'h1;
  localparam logic [CODE_W-1:0] CODE_PARTIAL = 4'h2;
  localparam logic [CODE_W-1:0] CODE_SLUMBER = 4'h6;
  localparam logic [CODE_W-1:0] CODE_DEVSLP  = 4'h8;
  localparam logic [CODE_W-1:0] PSTAT_SLUMBER = 4'h6;

  function automatic rq_t decode_code(input logic [CODE_W-1:0] c);
    case (c)
      CODE_ACTIVE:  decode_code = RQ_ACTIVE;
      CODE_PARTIAL: decode_code = RQ_PARTIAL;
      CODE_SLUMBER: decode_code = RQ_SLUMBER;
      CODE_DEVSLP:  decode_code = RQ_DEVSLP;
      default:      decode_code = RQ_NONE;
    endcase
  endfunction
endpackage

// File: rtl/lpr_cmd_field.sv
module lpr_cmd_field
  import lpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              link_idle,
  output logic [CODE_W-1:0] field_q,
  output rq_t               rq
);
  logic take;

  // A write lands only on an idle link and an empty field
  assign take = wr_en && link_idle && (field_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) field_q <= '0;
    else        field_q <= take ? wr_data : '0;
  end

  assign rq = decode_code(field_q);

  assert_field_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q != '0) |=> (field_q == '0));
  assert_busy_write_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !link_idle) |=> (field_q == '0));
endmodule

// File: rtl/lpr_hold_timer.sv
module lpr_hold_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic [TMR_W-1:0] count,
  output logic             expired
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (count != '0)    count <= count - 1'b1;
  end

  assign expired = (count == '0);

  assert_timer_counts_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count != '0) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/lpr_dslp_pin.sv
module lpr_dslp_pin #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_dslp,
  input  logic             exit_pend,
  input  logic             phy_ready,
  input  logic [TMR_W-1:0] hold_val,
  output logic             exit_fire,
  output logic             pin_q
);
  logic             seen_q;
  logic             pin_d;
  logic             load;
  logic             expired;
  logic [TMR_W-1:0] tmr;

  assign exit_fire = exit_pend && expired;

  always_comb begin
    pin_d = pin_q;
    if (exit_fire)                         pin_d = 1'b0;
    else if (in_dslp && !pin_q && seen_q)  pin_d = 1'b1;
  end

  assign load = !pin_q && pin_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
      if (exit_fire)      seen_q <= 1'b0;
      else if (phy_ready) seen_q <= 1'b1;
    end
  end

  lpr_hold_timer #(.TMR_W(TMR_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (hold_val),
    .count    (tmr),
    .expired  (expired)
  );

  assert_pin_only_in_dslp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_q |-> in_dslp);
  assert_pin_rise_after_phy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_q) |-> $past(seen_q));
  assert_pin_hold_elapsed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_q) |-> ($past(tmr) == '0));
endmodule

// File: rtl/lpr_state_ctrl.sv
module lpr_state_ctrl
  import lpr_pkg::*;
#(
  parameter int NSLOT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rq_t               rq,
  input  logic              exit_fire,
  input  logic [NSLOT-1:0]  cmd_issue,
  input  logic [NSLOT-1:0]  tag_active,
  input  logic              slumber_only,
  input  logic [CODE_W-1:0] pwr_status,
  input  logic              lp_grant,
  input  logic              lp_deny,
  output lstate_t           state_q,
  output logic              exit_pend_q,
  output logic              req_active,
  output logic              req_partial,
  output logic              req_slumber
);
  lstate_t state_d, tgt_q, tgt_d;
  logic    pend_q, pend_d, exit_d;
  logic    ra_d, rp_d, rs_d;
  logic    quiet, dslp_ok;

  assign quiet   = (cmd_issue == '0) && (tag_active == '0);
  assign dslp_ok = quiet && (!slumber_only || (pwr_status == PSTAT_SLUMBER));

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    pend_d  = pend_q;
    exit_d  = exit_pend_q;
    ra_d    = 1'b0;
    rp_d    = 1'b0;
    rs_d    = 1'b0;
    if (exit_fire) begin
      state_d = LS_ACTIVE;
      ra_d    = 1'b1;
      exit_d  = 1'b0;
    end else if (rq != RQ_NONE) begin
      case (rq)
        RQ_ACTIVE: begin
          if (state_q == LS_DEVSLP) exit_d = 1'b1;
          else begin
            if (state_q != LS_ACTIVE) begin
              state_d = LS_ACTIVE;
              ra_d    = 1'b1;
            end
            pend_d = 1'b0;
          end
        end
        RQ_PARTIAL: if (state_q == LS_ACTIVE) begin
          rp_d = 1'b1; pend_d = 1'b1; tgt_d = LS_PARTIAL;
        end
        RQ_SLUMBER: if (state_q == LS_ACTIVE) begin
          rs_d = 1'b1; pend_d = 1'b1; tgt_d = LS_SLUMBER;
        end
        RQ_DEVSLP: if (state_q != LS_DEVSLP && dslp_ok) begin
          state_d = LS_DEVSLP;
          pend_d  = 1'b0;
        end
        default: ;
      endcase
    end else if (pend_q && lp_grant) begin
      state_d = tgt_q;
      pend_d  = 1'b0;
    end else if (pend_q && lp_deny) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= LS_ACTIVE;
      tgt_q       <= LS_ACTIVE;
      pend_q      <= 1'b0;
      exit_pend_q <= 1'b0;
      req_active  <= 1'b0;
      req_partial <= 1'b0;
      req_slumber <= 1'b0;
    end else begin
      state_q     <= state_d;
      tgt_q       <= tgt_d;
      pend_q      <= pend_d;
      exit_pend_q <= exit_d;
      req_active  <= ra_d;
      req_partial <= rp_d;
      req_slumber <= rs_d;
    end
  end

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_active, req_partial, req_slumber}));
  assert_lp_req_from_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_partial || req_slumber) |-> (state_q == LS_ACTIVE));
  assert_dslp_entry_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == LS_DEVSLP) |-> $past(quiet));
  assert_dslp_entry_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == LS_DEVSLP) |-> $past(!slumber_only || pwr_status == PSTAT_SLUMBER));
  assert_active_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_active |-> (state_q == LS_ACTIVE));
endmodule

// File: rtl/link_pwr_req_ctrl.sv
module link_pwr_req_ctrl #(
  parameter int NSLOT = 32,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [3:0]       ctl_wr_data,
  input  logic             link_idle,
  input  logic [NSLOT-1:0] cmd_issue,
  input  logic [NSLOT-1:0] tag_active,
  input  logic             phy_ready,
  input  logic             dslp_slumber_only,
  input  logic [3:0]       pwr_status,
  input  logic             lp_grant,
  input  logic             lp_deny,
  input  logic [TMR_W-1:0] dslp_hold,
  output logic [3:0]       ctl_field,
  output logic [1:0]       link_state,
  output logic             req_active,
  output logic             req_partial,
  output logic             req_slumber,
  output logic             dslp_pin
);
  import lpr_pkg::*;

  rq_t     rq;
  lstate_t state;
  logic    exit_pend, exit_fire;

  lpr_cmd_field u_field (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctl_wr_en),
    .wr_data   (ctl_wr_data),
    .link_idle (link_idle),
    .field_q   (ctl_field),
    .rq        (rq)
  );

  lpr_state_ctrl #(.NSLOT(NSLOT)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .rq           (rq),
    .exit_fire    (exit_fire),
    .cmd_issue    (cmd_issue),
    .tag_active   (tag_active),
    .slumber_only (dslp_slumber_only),
    .pwr_status   (pwr_status),
    .lp_grant     (lp_grant),
    .lp_deny      (lp_deny),
    .state_q      (state),
    .exit_pend_q  (exit_pend),
    .req_active   (req_active),
    .req_partial  (req_partial),
    .req_slumber  (req_slumber)
  );

  lpr_dslp_pin #(.TMR_W(TMR_W)) u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_dslp   (state == LS_DEVSLP),
    .exit_pend (exit_pend),
    .phy_ready (phy_ready),
    .hold_val  (dslp_hold),
    .exit_fire (exit_fire),
    .pin_q     (dslp_pin)
  );

  assign link_state = state;
endmodule

// File: tb/link_pwr_req_ctrl_bench.sv
module link_pwr_req_ctrl_bench;
  localparam int NSLOT = 32;
  localparam int TMR_W = 8;
  localparam int HOLD  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr_en = 1'b0;
  logic [3:0] ctl_wr_data = '0;
  logic link_idle = 1'b1;
  logic [NSLOT-1:0] cmd_issue = '0, tag_active = '0;
  logic phy_ready = 1'b0, dslp_slumber_only = 1'b0;
  logic [3:0] pwr_status = '0;
  logic lp_grant = 1'b0, lp_deny = 1'b0;
  logic [TMR_W-1:0] dslp_hold = TMR_W'(HOLD);
  logic [3:0] ctl_field;
  logic [1:0] link_state;
  logic req_active, req_partial, req_slumber, dslp_pin;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  link_pwr_req_ctrl #(.NSLOT(NSLOT), .TMR_W(TMR_W)) u_link_pwr_req_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .link_idle(link_idle), .cmd_issue(cmd_issue), .tag_active(tag_active),
    .phy_ready(phy_ready), .dslp_slumber_only(dslp_slumber_only),
    .pwr_status(pwr_status), .lp_grant(lp_grant), .lp_deny(lp_deny),
    .dslp_hold(dslp_hold), .ctl_field(ctl_field), .link_state(link_state),
    .req_active(req_active), .req_partial(req_partial),
    .req_slumber(req_slumber), .dslp_pin(dslp_pin));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, stepped on every rising edge
  int m_field, m_state, m_tgt, m_tmr;
  bit m_pend, m_exit, m_pin, m_seen, m_ra, m_rp, m_rs, m_live;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_field = 0; m_state = 0; m_tgt = 0; m_tmr = 0;
      m_pend = 0; m_exit = 0; m_pin = 0; m_seen = 0;
      m_ra = 0; m_rp = 0; m_rs = 0; m_live = 0;
    end else begin
      int st, nst, ntgt, ntmr, nfield;
      bit fire, npend, nexit, npin, nseen, iscmd, okd;
      st = m_state; nst = st; ntgt = m_tgt; npend = m_pend; nexit = m_exit;
      fire = m_exit && (m_tmr == 0);
      nfield = (ctl_wr_en && link_idle && m_field == 0) ? int'(ctl_wr_data) : 0;
      iscmd = (m_field == 1 || m_field == 2 || m_field == 6 || m_field == 8);
      okd = (cmd_issue == 0) && (tag_active == 0) && (!dslp_slumber_only || pwr_status == 6);
      m_ra = 0; m_rp = 0; m_rs = 0;
      if (fire) begin nst = 0; m_ra = 1; nexit = 0; end
      else if (iscmd) begin
        if (m_field == 1) begin
          if (st == 3) nexit = 1;
          else begin if (st != 0) begin nst = 0; m_ra = 1; end npend = 0; end
        end else if (m_field == 2) begin
          if (st == 0) begin m_rp = 1; npend = 1; ntgt = 1; end
        end else if (m_field == 6) begin
          if (st == 0) begin m_rs = 1; npend = 1; ntgt = 2; end
        end else if (st != 3 && okd) begin nst = 3; npend = 0; end
      end else if (m_pend && lp_grant) begin nst = m_tgt; npend = 0; end
      else if (m_pend && lp_deny) npend = 0;
      npin = m_pin;
      if (fire) npin = 0;
      else if (st == 3 && !m_pin && m_seen) npin = 1;
      ntmr = (!m_pin && npin) ? HOLD : (m_tmr > 0 ? m_tmr - 1 : 0);
      nseen = fire ? 0 : (phy_ready ? 1 : m_seen);
      m_field = nfield; m_state = nst; m_tgt = ntgt; m_pend = npend;
      m_exit = nexit; m_pin = npin; m_tmr = ntmr; m_seen = nseen; m_live = 1;
    end
  end

  always @(negedge clk) begin
    if (m_live && rst_n) begin
      chk("R2", "model field", int'(ctl_field), m_field);
      chk("R3", "model state", int'(link_state), m_state);
      chk("R9", "model pin", int'(dslp_pin), int'(m_pin));
      chk("R3", "model strobes", int'({req_active, req_partial, req_slumber}),
          int'({m_ra, m_rp, m_rs}));
    end
  end

  task automatic wr(input logic [3:0] c);
    @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = c;
    @(negedge clk); ctl_wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset field", int'(ctl_field), 0);
    chk("R1", "reset state", int'(link_state), 0);
    chk("R1", "reset pin", int'(dslp_pin), 0);
    chk("R1", "reset strobes", int'({req_active, req_partial, req_slumber}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    wr(4'h2); chk("R2", "field shows code", int'(ctl_field), 2);
    @(negedge clk); chk("R3", "partial strobe", int'(req_partial), 1);
    chk("R2", "field back to 0", int'(ctl_field), 0);
    lp_grant = 1'b1; @(negedge clk); lp_grant = 1'b0;
    chk("R3", "granted partial", int'(link_state), 1);

    wr(4'h6); @(negedge clk);
    chk("R5", "no slumber from partial", int'(req_slumber), 0);
    chk("R5", "state kept partial", int'(link_state), 1);
    wr(4'h2); @(negedge clk);
    chk("R4", "same state no strobe", int'(req_partial), 0);

    wr(4'h1); @(negedge clk);
    chk("R6", "active strobe", int'(req_active), 1);
    chk("R6", "state active", int'(link_state), 0);

    wr(4'h6); @(negedge clk);
    chk("R3", "slumber strobe", int'(req_slumber), 1);
    lp_deny = 1'b1; @(negedge clk); lp_deny = 1'b0;
    chk("R3", "denied stays active", int'(link_state), 0);
    wr(4'h1); @(negedge clk);
    chk("R4", "active while active", int'(req_active), 0);

    link_idle = 1'b0; wr(4'h2);
    chk("R2", "busy write dropped", int'(ctl_field), 0);
    @(negedge clk); chk("R2", "no strobe busy", int'(req_partial), 0);
    link_idle = 1'b1;

    wr(4'h5); chk("R11", "reserved readback", int'(ctl_field), 5);
    @(negedge clk); chk("R11", "reserved cleared", int'(ctl_field), 0);
    chk("R11", "reserved no strobe", int'({req_active, req_partial, req_slumber}), 0);
    chk("R11", "reserved no state", int'(link_state), 0);

    cmd_issue = 32'h1; wr(4'h8); @(negedge clk);
    chk("R7", "busy cmd issue", int'(link_state), 0);
    cmd_issue = '0; tag_active = 32'h10; wr(4'h8); @(negedge clk);
    chk("R7", "busy tags", int'(link_state), 0);
    tag_active = '0;

    dslp_slumber_only = 1'b1; pwr_status = 4'h0; wr(4'h8); @(negedge clk);
    chk("R8", "cap blocks entry", int'(link_state), 0);
    pwr_status = 4'h6; wr(4'h8); @(negedge clk);
    chk("R8", "entry in slumber status", int'(link_state), 3);

    repeat (3) @(negedge clk);
    chk("R9", "pin waits for phy", int'(dslp_pin), 0);
    phy_ready = 1'b1;
    @(negedge clk); chk("R9", "pin one edge later", int'(dslp_pin), 0);
    @(negedge clk); chk("R9", "pin asserted", int'(dslp_pin), 1);
    begin
      int hi = 1;
      wr(4'h1); hi += 2;
      for (int g = 0; g < 200 && dslp_pin; g++) begin
        @(negedge clk);
        if (dslp_pin) hi++;
      end
      chk("R10", "pin high cycles", hi, HOLD + 1);
      chk("R10", "exit strobe", int'(req_active), 1);
      chk("R10", "exit state", int'(link_state), 0);
    end

    dslp_slumber_only = 1'b0; pwr_status = 4'h0;
    wr(4'h8); @(negedge clk);
    chk("R8", "entry from active when cap 0", int'(link_state), 3);
    repeat (4) @(negedge clk);
    chk("R9", "pin after fresh phy", int'(dslp_pin), 1);
    wr(4'h2); @(negedge clk);
    chk("R5", "partial from dslp dropped", int'(req_partial), 0);
    wr(4'h1);
    repeat (HOLD + 5) @(negedge clk);
    chk("R10", "released", int'(dslp_pin), 0);
    repeat (4) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule